// File: doc/BRIEF.md
# Power-management register file with interrupt logic

This block holds the 16-bit registers of a power-management companion chip. A serial-bus slave front end turns each bus frame into a one-cycle access on this block's parallel port. An access gives a valid strobe, a write flag, a register index and write data. Reads return through a registered data output one cycle later. The index space has 32 entries. Indices above that do not exist and raise an error pulse. Registers that are not implemented inside the range read as zero.

Two registers drive the single interrupt line: an interrupt status word and an interrupt mask word. A write to the status word toggles the bits it names. A set mask bit disables that source. Two events raise status bits directly. A write to the converter register signals "sample done". A power-key event signals a key change and also records the key level in the status register. A 16-entry per-channel result table sits behind the converter register and is loaded through a side port. A watchdog register requests power-off when software writes zero to it, but only while a control bit allows it.

Top module: `pmic_regfile`

## Requirements
- R1: `irq_o` is high exactly when some interrupt-status bit is 1 while its mask bit is 0. After reset the mask is 0xFFFF, the status is 0x0000 and `irq_o` is low.
- R2: A write to index 0x01 XORs the write data into the interrupt status. A read of index 0x01 returns the raw status.
- R3: Index 0x02 is the read/write interrupt mask. `irq_o` reflects a new mask in the cycle after the write.
- R4: Index 0x00 reads 0x0215, with bit 7 set when `variant_i` is high. Writes to it are ignored.
- R5: A read of index 0x08 returns the selected channel in bits 13:10 and that channel's 10-bit table entry in bits 9:0. Bits 15:14 read 0.
- R6: A write to index 0x08 loads the channel from write-data bits 13:10 and sets interrupt-status bit 8.
- R7: Index 0x09 resets to 0x00FF. A write clears every bit that is 1 in the write data and leaves the other bits unchanged.
- R8: A write of 0x0000 to index 0x17 while bit 1 of index 0x0D is 1 raises `shutdown_o` in the next cycle. Once high it stays high until reset. Any other watchdog write has no effect.
- R9: A cycle with `key_evt_i` high sets interrupt-status bit 0. It also sets bit 5 of the status register at index 0x16 to the inverse of `key_down_i`. That register resets to 0x0020 and ignores writes.
- R10: Index 0x06 resets to 0x0001. Indices 0x06, 0x0D and 0x0E are plain read/write registers, and 0x0D and 0x0E reset to 0.
- R11: Any other index below 32 reads 0 and ignores writes, and `err_o` stays low for it.
- R12: An access to an index of 32 or more drives `err_o` high for exactly the next cycle. Such a read returns 0.
- R13: A side-port write with `tbl_we_i` high stores `tbl_val_i` as the result of channel `tbl_ch_i`.
- R14: `acc_rdata` changes only in the cycle after a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_idx | input | ADDR_W | Register index |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid the cycle after a read |
| variant_i | input | 1 | Variant strap shown in the identification word |
| key_evt_i | input | 1 | One-cycle power-key change event |
| key_down_i | input | 1 | Key level at the event, 1 = pressed |
| tbl_we_i | input | 1 | Result-table write enable |
| tbl_ch_i | input | 4 | Result-table channel |
| tbl_val_i | input | RES_W | Result-table value |
| irq_o | output | 1 | Interrupt request |
| shutdown_o | output | 1 | Sticky power-off request |
| err_o | output | 1 | One-cycle out-of-range access flag |

## Verification
The power-off request is the hardest case to reach. It needs control register bit 1 to be set first. The watchdog write must then carry exactly zero. A nonzero write with the enable set, and a zero write with the enable clear, must both leave the request low. The bench walks these three cases in order, then clears the enable to show that the request stays high. Interrupt masking is tested by opening one mask bit at a time while toggling status bits from the bus and from the converter and key events.

// File: rtl/pmic_pkg.sv
package pmic_pkg;
    localparam int DW = 16;
    typedef logic [DW-1:0] word_t;

    typedef enum logic [4:0] {
        IX_ID       = 5'h00,
        IX_IRQ_ID   = 5'h01,
        IX_IRQ_MASK = 5'h02,
        IX_CAL      = 5'h06,
        IX_ADC      = 5'h08,
        IX_SAMPLE   = 5'h09,
        IX_CTRL1    = 5'h0D,
        IX_CTRL2    = 5'h0E,
        IX_STATUS   = 5'h16,
        IX_WDOG     = 5'h17
    } reg_idx_e;

    localparam word_t ID_BASE       = 16'h0215;
    localparam int    VARIANT_BIT   = 7;
    localparam word_t STATUS_RESET  = 16'h0020;
    localparam word_t CAL_RESET     = 16'h0001;
    localparam int    ADC_DONE_BIT  = 8;
    localparam int    KEY_IRQ_BIT   = 0;
    localparam int    KEY_STAT_BIT  = 5;
    localparam int    SHDN_EN_BIT   = 1;
    localparam int    ADC_CH_LSB    = 10;
endpackage

// File: rtl/pmic_irq.sv
module pmic_irq #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xor_we,
    input  logic [DW-1:0] xor_val,
    input  logic          mask_we,
    input  logic [DW-1:0] mask_val,
    input  logic [DW-1:0] set_bits,
    output logic [DW-1:0] stat_o,
    output logic [DW-1:0] mask_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [DW-1:0] stat;
        logic [DW-1:0] mask;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (xor_we)  st_d.stat = st_q.stat ^ xor_val;
        if (mask_we) st_d.mask = mask_val;
        // hardware events win over a same-cycle toggle
        st_d.stat = st_d.stat | set_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stat <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.stat & ~st_q.mask);
endmodule

// File: rtl/pmic_adc.sv
module pmic_adc #(
    parameter int          DW          = 16,
    parameter int          CH_W        = 4,
    parameter int          RES_W       = 10,
    parameter int          CH_LSB      = 10,
    parameter logic [15:0] SAMPLE_INIT = 16'h00FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_we,
    input  logic [CH_W-1:0]  ch_val,
    input  logic             smp_clr_we,
    input  logic [DW-1:0]    smp_clr,
    input  logic             tbl_we,
    input  logic [CH_W-1:0]  tbl_ch,
    input  logic [RES_W-1:0] tbl_val,
    output logic [DW-1:0]    adc_word,
    output logic [DW-1:0]    sample_o
);
    localparam int NCH = 1 << CH_W;

    typedef struct packed {
        logic [CH_W-1:0]             ch;
        logic [DW-1:0]               sample;
        logic [NCH-1:0][RES_W-1:0]   tbl;
    } adc_st_t;

    adc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ch_we)      st_d.ch = ch_val;
        if (smp_clr_we) st_d.sample = st_q.sample & ~smp_clr;
        if (tbl_we)     st_d.tbl[tbl_ch] = tbl_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ch     <= '0;
            st_q.sample <= DW'(SAMPLE_INIT);
            st_q.tbl    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        adc_word = '0;
        adc_word[CH_LSB +: CH_W] = st_q.ch;
        adc_word[RES_W-1:0]      = st_q.tbl[st_q.ch];
    end

    assign sample_o = st_q.sample;
endmodule

// File: rtl/pmic_regfile.sv
module pmic_regfile
    import pmic_pkg::*;
#(
    parameter int          ADDR_W      = 6,
    parameter int          RES_W       = 10,
    parameter logic [15:0] SAMPLE_INIT = 16'h00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_idx,
    input  logic [15:0]       acc_wdata,
    output logic [15:0]       acc_rdata,
    input  logic              variant_i,
    input  logic              key_evt_i,
    input  logic              key_down_i,
    input  logic              tbl_we_i,
    input  logic [3:0]        tbl_ch_i,
    input  logic [RES_W-1:0]  tbl_val_i,
    output logic              irq_o,
    output logic              shutdown_o,
    output logic              err_o
);
    localparam int                NUM_REGS = 32;
    localparam int                CH_W     = 4;
    localparam logic [ADDR_W:0]   LIMIT    = (ADDR_W+1)'(NUM_REGS);

    typedef struct packed {
        word_t cal;
        word_t ctrl1;
        word_t ctrl2;
        word_t status;
        word_t rdata;
        logic  shdn;
        logic  err;
    } top_st_t;

    top_st_t st_d, st_q;

    logic       in_range, wr, rd;
    logic [4:0] idx5;
    word_t      irq_stat, irq_mask, adc_word, sample, set_bits, rval;
    word_t      ctrl1_w;

    assign in_range = ({1'b0, acc_idx} < LIMIT);
    assign idx5     = acc_idx[4:0];
    assign wr       = acc_valid && acc_write && in_range;
    assign rd       = acc_valid && !acc_write;
    assign ctrl1_w  = st_q.ctrl1;

    always_comb begin
        set_bits = '0;
        set_bits[ADC_DONE_BIT] = wr && (idx5 == IX_ADC);
        set_bits[KEY_IRQ_BIT]  = key_evt_i;
    end

    pmic_irq #(.DW(DW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .xor_we   (wr && (idx5 == IX_IRQ_ID)),
        .xor_val  (acc_wdata),
        .mask_we  (wr && (idx5 == IX_IRQ_MASK)),
        .mask_val (acc_wdata),
        .set_bits (set_bits),
        .stat_o   (irq_stat),
        .mask_o   (irq_mask),
        .irq_o    (irq_o)
    );

    pmic_adc #(
        .DW(DW), .CH_W(CH_W), .RES_W(RES_W),
        .CH_LSB(ADC_CH_LSB), .SAMPLE_INIT(SAMPLE_INIT)
    ) u_adc (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_we      (wr && (idx5 == IX_ADC)),
        .ch_val     (acc_wdata[ADC_CH_LSB +: CH_W]),
        .smp_clr_we (wr && (idx5 == IX_SAMPLE)),
        .smp_clr    (acc_wdata),
        .tbl_we     (tbl_we_i),
        .tbl_ch     (tbl_ch_i),
        .tbl_val    (tbl_val_i),
        .adc_word   (adc_word),
        .sample_o   (sample)
    );

    // read mux
    always_comb begin
        case (idx5)
            IX_ID:       rval = ID_BASE | (word_t'(variant_i) << VARIANT_BIT);
            IX_IRQ_ID:   rval = irq_stat;
            IX_IRQ_MASK: rval = irq_mask;
            IX_CAL:      rval = st_q.cal;
            IX_ADC:      rval = adc_word;
            IX_SAMPLE:   rval = sample;
            IX_CTRL1:    rval = st_q.ctrl1;
            IX_CTRL2:    rval = st_q.ctrl2;
            IX_STATUS:   rval = st_q.status;
            default:     rval = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = acc_valid && !in_range;
        if (rd) st_d.rdata = in_range ? rval : '0;
        if (wr) begin
            case (idx5)
                IX_CAL:   st_d.cal   = acc_wdata;
                IX_CTRL1: st_d.ctrl1 = acc_wdata;
                IX_CTRL2: st_d.ctrl2 = acc_wdata;
                IX_WDOG:  if (acc_wdata == '0 && st_q.ctrl1[SHDN_EN_BIT]) st_d.shdn = 1'b1;
                default:  ;
            endcase
        end
        if (key_evt_i) st_d.status[KEY_STAT_BIT] = !key_down_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cal    <= CAL_RESET;
            st_q.ctrl1  <= '0;
            st_q.ctrl2  <= '0;
            st_q.status <= STATUS_RESET;
            st_q.rdata  <= '0;
            st_q.shdn   <= 1'b0;
            st_q.err    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_rdata  = st_q.rdata;
    assign shutdown_o = st_q.shdn;
    assign err_o      = st_q.err;
endmodule

// File: rtl/pmic_regfile_chk.sv
module pmic_regfile_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_idx,
    input logic [15:0]       acc_wdata,
    input logic              key_evt_i,
    input logic              irq_o,
    input logic              shutdown_o,
    input logic              err_o,
    input logic [15:0]       irq_stat,
    input logic [15:0]       irq_mask,
    input logic [15:0]       ctrl1_w
);
    logic wr_any;
    assign wr_any = acc_valid && acc_write;

    p_mask_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && acc_idx == ADDR_W'(2) && acc_wdata == 16'hFFFF) |=> !irq_o);

    p_adc_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && acc_idx == ADDR_W'(8) && !irq_mask[8]) |=> irq_o);

    p_shdn_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && acc_idx == ADDR_W'(23) && acc_wdata == 16'h0000 && ctrl1_w[1]) |=> shutdown_o);

    p_shdn_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |=> shutdown_o);

    p_key_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        key_evt_i |=> irq_stat[0]);

    p_err_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_idx >= ADDR_W'(32)) |=> err_o);

    p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !err_o);
endmodule

bind pmic_regfile pmic_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_idx    (acc_idx),
    .acc_wdata  (acc_wdata),
    .key_evt_i  (key_evt_i),
    .irq_o      (irq_o),
    .shutdown_o (shutdown_o),
    .err_o      (err_o),
    .irq_stat   (irq_stat),
    .irq_mask   (irq_mask),
    .ctrl1_w    (ctrl1_w)
);

// File: tb/pmic_regfile_tb.sv
module pmic_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int RES_W      = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0, acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_idx = '0;
    logic [15:0]       acc_wdata = '0;
    logic [15:0]       acc_rdata;
    logic              variant_i = 1'b0, key_evt_i = 1'b0, key_down_i = 1'b0;
    logic              tbl_we_i = 1'b0;
    logic [3:0]        tbl_ch_i = '0;
    logic [RES_W-1:0]  tbl_val_i = '0;
    logic              irq_o, shutdown_o, err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmic_regfile #(.ADDR_W(ADDR_W), .RES_W(RES_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_idx(acc_idx),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .variant_i(variant_i), .key_evt_i(key_evt_i), .key_down_i(key_down_i),
        .tbl_we_i(tbl_we_i), .tbl_ch_i(tbl_ch_i), .tbl_val_i(tbl_val_i),
        .irq_o(irq_o), .shutdown_o(shutdown_o), .err_o(err_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%04h expected=%04h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input int idx, input logic [15:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_idx = ADDR_W'(idx); acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [15:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_idx = ADDR_W'(idx);
        @(negedge clk);
        acc_valid = 1'b0;
        d = acc_rdata;
    endtask

    task automatic rd_chk(input string req, input int idx, input logic [15:0] exp);
        logic [15:0] v;
        rd(idx, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset();
        chk("R1 irq after reset", 16'(irq_o), 16'h0);
        chk("R8 shutdown after reset", 16'(shutdown_o), 16'h0);
        rd_chk("R4 id", 0, 16'h0215);
        rd_chk("R1 mask reset", 2, 16'hFFFF);
        rd_chk("R1 status reset", 1, 16'h0000);
        rd_chk("R9 key status reset", 22, 16'h0020);
        rd_chk("R10 cal reset", 6, 16'h0001);
        rd_chk("R10 ctrl1 reset", 13, 16'h0000);
        rd_chk("R7 sample reset", 9, 16'h00FF);
    endtask

    task automatic t_ident();
        variant_i = 1'b1;
        rd_chk("R4 id variant", 0, 16'h0295);
        wr(0, 16'hFFFF);
        rd_chk("R4 id write ignored", 0, 16'h0295);
        variant_i = 1'b0;
    endtask

    task automatic t_irq();
        wr(1, 16'h0005);
        rd_chk("R2 xor sets", 1, 16'h0005);
        chk("R1 all masked", 16'(irq_o), 16'h0);
        wr(2, 16'hFFFE);
        chk("R3 unmask bit0", 16'(irq_o), 16'h1);
        rd_chk("R3 mask readback", 2, 16'hFFFE);
        wr(1, 16'h0001);
        rd_chk("R2 xor clears", 1, 16'h0004);
        chk("R1 source gone", 16'(irq_o), 16'h0);
        wr(2, 16'hFFFB);
        chk("R3 unmask bit2", 16'(irq_o), 16'h1);
        wr(1, 16'h0004);
        chk("R2 toggle off irq", 16'(irq_o), 16'h0);
        wr(2, 16'hFFFF);
    endtask

    task automatic t_adc();
        @(negedge clk);
        tbl_we_i = 1'b1; tbl_ch_i = 4'd3; tbl_val_i = 10'h165;
        @(negedge clk);
        tbl_ch_i = 4'd12; tbl_val_i = 10'h3D0;
        @(negedge clk);
        tbl_we_i = 1'b0;
        wr(2, 16'hFEFF);
        wr(8, 16'h0C00);
        chk("R6 adc done irq", 16'(irq_o), 16'h1);
        rd_chk("R5 R13 adc ch3", 8, 16'h0D65);
        rd_chk("R6 status bit8", 1, 16'h0100);
        wr(8, 16'h3000);
        rd_chk("R5 R13 adc ch12", 8, 16'h33D0);
        wr(8, 16'hC000);
        rd_chk("R5 R6 adc ch0 upper bits dropped", 8, 16'h0000);
        wr(1, 16'h0100);
        chk("R2 adc irq cleared", 16'(irq_o), 16'h0);
        wr(2, 16'hFFFF);
    endtask

    task automatic t_regs();
        wr(9, 16'h000F);
        rd_chk("R7 clear low nibble", 9, 16'h00F0);
        wr(9, 16'hFF00);
        rd_chk("R7 clear of zero bits", 9, 16'h00F0);
        wr(9, 16'h0030);
        rd_chk("R7 clear two bits", 9, 16'h00C0);
        wr(6, 16'h1234);
        rd_chk("R10 cal rw", 6, 16'h1234);
        wr(14, 16'hBEEF);
        rd_chk("R10 ctrl2 rw", 14, 16'hBEEF);
        wr(22, 16'h0000);
        rd_chk("R9 status write ignored", 22, 16'h0020);
    endtask

    task automatic t_key();
        @(negedge clk); key_evt_i = 1'b1; key_down_i = 1'b1;
        @(negedge clk); key_evt_i = 1'b0;
        rd_chk("R9 pressed status", 22, 16'h0000);
        rd_chk("R9 key irq bit", 1, 16'h0001);
        wr(2, 16'hFFFE);
        chk("R9 key irq out", 16'(irq_o), 16'h1);
        @(negedge clk); key_evt_i = 1'b1; key_down_i = 1'b0;
        @(negedge clk); key_evt_i = 1'b0;
        rd_chk("R9 released status", 22, 16'h0020);
        wr(1, 16'h0001);
        wr(2, 16'hFFFF);
    endtask

    task automatic t_unimpl_err();
        logic [15:0] v;
        wr(7, 16'hFFFF);
        chk("R11 no err", 16'(err_o), 16'h0);
        rd_chk("R11 unimpl reads zero", 7, 16'h0000);
        rd_chk("R11 top index zero", 31, 16'h0000);
        rd(2, v);
        repeat (3) @(negedge clk);
        chk("R14 rdata holds", acc_rdata, 16'hFFFF);
        wr(40, 16'h1234);
        chk("R12 err pulse", 16'(err_o), 16'h1);
        @(negedge clk);
        chk("R12 err one cycle", 16'(err_o), 16'h0);
        rd(33, v);
        chk("R12 oob read zero", v, 16'h0000);
        chk("R12 err on read", 16'(err_o), 16'h1);
        rd_chk("R12 cal unaffected", 6, 16'h1234);
    endtask

    task automatic t_wdog();
        wr(13, 16'h0000);
        wr(23, 16'h0000);
        chk("R8 disabled no shutdown", 16'(shutdown_o), 16'h0);
        wr(13, 16'h0002);
        wr(23, 16'h0005);
        chk("R8 nonzero no shutdown", 16'(shutdown_o), 16'h0);
        wr(23, 16'h0000);
        chk("R8 shutdown raised", 16'(shutdown_o), 16'h1);
        wr(13, 16'h0000);
        chk("R8 shutdown sticky", 16'(shutdown_o), 16'h1);
        do_reset();
        chk("R8 cleared by reset", 16'(shutdown_o), 16'h0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        t_reset();
        t_ident();
        t_irq();
        t_adc();
        t_regs();
        t_key();
        t_unimpl_err();
        t_wdog();
        finish_run();
    end
endmodule